// File: doc/BRIEF.md
# Two-Wire Bus Master with Multi-Master Arbitration

This block is a byte-oriented controller that runs transfers on an I2C-compatible two-wire bus. A host posts one command naming a 7-bit target address, a direction, a byte count and a rate. The block then produces the START condition, the address byte, the data bytes with their acknowledge slots, and the closing STOP. It drives the clock and data wires only through open-drain enables. A `1` on an enable pulls the wire low, and a `0` releases it to the pull-up.

Both wire inputs pass through a digital deglitch stage before the control logic sees them. The block can share the bus with other masters. It compares every `1` it sends against the level it reads back. If another master holds the wire low, the block lets go of both wires and reports that it lost arbitration. Write bytes come from the host through a take strobe, and read bytes go back through a valid strobe. The block ends each command with a one-cycle done pulse, which comes with a NACK flag and an arbitration-lost flag.

Top module: `i2c_arb_master`

## Requirements
- R1: After START (SDA falls while SCL is high), the first byte on the wire is the 7-bit address followed by the direction bit (1 = read, 0 = write), sent MSB first. Its acknowledge is sampled in the ninth clock.
- R2: On a write, each data byte is taken from `tx_data` in the cycle `tx_take` pulses and is sent MSB first. Exactly one `tx_take` pulse occurs per byte put on the wire.
- R3: On a read, each byte is shifted in MSB first and presented on `rx_data` with a one-cycle `rx_valid`. The master drives ACK (SDA low) in the ninth clock of every byte except the last, leaves SDA high (NACK) on the last byte, and then sends STOP.
- R4: A NACK (SDA high in the ninth clock) on the address byte or on any write byte ends the command with STOP and `nack` = 1, and no further data byte is sent.
- R5: A write command with a count of 0 sends only the address byte and then STOP, with no `tx_take` pulse. Read commands need a count of at least 1.
- R6: Every SCL low phase driven by the master lasts exactly HALF+1 system clocks, where HALF is `HALF_FAST` when `cmd_fast` = 1 and `HALF_STD` otherwise.
- R7: The high-phase timer starts only once the filtered SCL reads high. A target holding SCL low stretches the bit without corrupting any data.
- R8: If the master releases SDA for a `1` in the address byte or in a write byte, but samples it low at the end of the high phase, it releases SCL and SDA in the same cycle. It then pulses `done` with `arb_lost` = 1 and drives no further SCL pulse.
- R9: A level change on either input that lasts fewer than `FILT_LEN` system clocks is ignored, so a 2-clock low pulse on SDA during a transmitted `1` causes no arbitration loss.
- R10: `cmd_ready` is high only while the block is idle and both filtered wires have been high. While another device holds SDA low on an idle bus, no command is accepted.
- R11: After reset, both enables are released, `done`, `tx_take` and `rx_valid` are low, and `cmd_ready` rises once both wires read high.
- R12: `done` is a single-cycle pulse, and `nack` and `arb_lost` hold their value from that pulse until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host presents a command |
| cmd_ready | output | 1 | Block accepts a command this cycle |
| cmd_addr | input | 7 | Target address |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_len | input | CNT_W | Number of data bytes |
| cmd_fast | input | 1 | 1 = fast rate, 0 = standard rate |
| tx_data | input | 8 | Next byte to write |
| tx_take | output | 1 | Pulse: `tx_data` was taken |
| rx_data | output | 8 | Last byte read |
| rx_valid | output | 1 | Pulse: `rx_data` is new |
| done | output | 1 | Pulse: command finished |
| nack | output | 1 | Target did not acknowledge |
| arb_lost | output | 1 | Arbitration was lost |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
The arbitration comparison and the deglitch stage both act on the same sample of SDA at the end of a high phase. A disturbance at that instant must therefore be either ignored or treated as a loss, depending only on its length. The bench places a 2-clock low pulse, visible only to the master, just ahead of the sample point of a transmitted `1`, and expects a clean transfer. It also has a second master pull SDA low for the whole of an address bit that is `1`, and expects `arb_lost`, both wires released at once, and no further clock pulses. Random commands that mix read and write, both rates, NACK positions and clock stretching are compared against the bytes that a target model in the bench records and returns.

// File: rtl/i2c_pkg.sv
package i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LO,
    ST_HI,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_END
  } state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_WR,
    K_RD
  } kind_t;
endpackage

// File: rtl/i2c_deglitch.sv
module i2c_deglitch #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(STABLE + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      dout    <= 1'b1;
      run_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        run_cnt <= '0;
      end else if (run_cnt == CW'(STABLE - 1)) begin
        dout    <= sync_q[1];
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R9
  filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> ($past(sync_q[1]) == dout));
endmodule

// File: rtl/i2c_halfbit_timer.sv
module i2c_halfbit_timer #(
  parameter int HALF_STD  = 250,
  parameter int HALF_FAST = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic fast,
  output logic expired
);
  localparam int HMAX = (HALF_STD > HALF_FAST) ? HALF_STD : HALF_FAST;
  localparam int TW   = $clog2(HMAX + 2);

  logic [TW-1:0] cnt;
  logic [TW-1:0] lim;

  assign lim     = fast ? TW'(HALF_FAST - 1) : TW'(HALF_STD - 1);
  assign expired = run && !clr && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  // R6
  tmr_single_chk: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired);
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
  import i2c_pkg::*;
#(
  parameter int FILT_LEN  = 4,
  parameter int HALF_STD  = 250,
  parameter int HALF_FAST = 63,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [6:0]       cmd_addr,
  input  logic             cmd_read,
  input  logic [CNT_W-1:0] cmd_len,
  input  logic             cmd_fast,
  input  logic [7:0]       tx_data,
  output logic             tx_take,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             done,
  output logic             nack,
  output logic             arb_lost,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] pin_raw;
  logic [NLINES-1:0] pin_f;
  logic              scl_f;
  logic              sda_f;

  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_deglitch #(.STABLE(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (pin_raw[g]),
      .dout (pin_f[g])
    );
  end

  assign scl_f = pin_f[0];
  assign sda_f = pin_f[1];

  state_t           state;
  kind_t            kind;
  logic             rd_q;
  logic             fast_q;
  logic [7:0]       shreg;
  logic [3:0]       bitn;
  logic [CNT_W-1:0] left;
  logic             tmr_clr;
  logic             tmr_run;
  logic             tmr_exp;
  logic             drv;

  assign tmr_run = (state == ST_HI || state == ST_STOP_HI) ? scl_f : 1'b1;

  i2c_halfbit_timer #(.HALF_STD(HALF_STD), .HALF_FAST(HALF_FAST)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .run     (tmr_run),
    .fast    (fast_q),
    .expired (tmr_exp)
  );

  // level to pull SDA to during the low phase of the current slot
  always_comb begin
    if (bitn == 4'd8) drv = (kind == K_RD) ? (left != '0) : 1'b0;
    else              drv = (kind == K_RD) ? 1'b0 : ~shreg[7];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      rd_q      <= 1'b0;
      fast_q    <= 1'b0;
      shreg     <= '0;
      bitn      <= '0;
      left      <= '0;
      tmr_clr   <= 1'b1;
      cmd_ready <= 1'b0;
      tx_take   <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      done      <= 1'b0;
      nack      <= 1'b0;
      arb_lost  <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      tx_take  <= 1'b0;
      rx_valid <= 1'b0;
      done     <= 1'b0;
      tmr_clr  <= 1'b0;
      case (state)
        ST_IDLE: begin
          scl_oe    <= 1'b0;
          sda_oe    <= 1'b0;
          cmd_ready <= scl_f && sda_f && !(cmd_valid && cmd_ready);
          if (cmd_valid && cmd_ready) begin
            shreg    <= {cmd_addr, cmd_read};
            kind     <= K_ADDR;
            rd_q     <= cmd_read;
            fast_q   <= cmd_fast;
            left     <= cmd_len;
            nack     <= 1'b0;
            arb_lost <= 1'b0;
            sda_oe   <= 1'b1;
            tmr_clr  <= 1'b1;
            state    <= ST_START;
          end
        end
        ST_START: begin
          if (tmr_exp) begin
            scl_oe  <= 1'b1;
            bitn    <= '0;
            tmr_clr <= 1'b1;
            state   <= ST_LO;
          end
        end
        ST_LO: begin
          sda_oe <= drv;
          if (tmr_exp) begin
            scl_oe  <= 1'b0;
            tmr_clr <= 1'b1;
            state   <= ST_HI;
          end
        end
        ST_HI: begin
          if (tmr_exp) begin
            tmr_clr <= 1'b1;
            if (bitn != 4'd8) begin
              if (kind != K_RD && shreg[7] && !sda_f) begin
                scl_oe   <= 1'b0;
                sda_oe   <= 1'b0;
                arb_lost <= 1'b1;
                done     <= 1'b1;
                state    <= ST_IDLE;
              end else begin
                shreg  <= {shreg[6:0], sda_f};
                bitn   <= bitn + 1'b1;
                scl_oe <= 1'b1;
                state  <= ST_LO;
                if (kind == K_RD && bitn == 4'd7) begin
                  rx_data  <= {shreg[6:0], sda_f};
                  rx_valid <= 1'b1;
                end
              end
            end else begin
              scl_oe <= 1'b1;
              if (kind != K_RD && sda_f) begin
                nack  <= 1'b1;
                state <= ST_STOP_LO;
              end else if (left == '0) begin
                state <= ST_STOP_LO;
              end else begin
                left  <= left - 1'b1;
                bitn  <= '0;
                state <= ST_LO;
                if (rd_q) begin
                  kind <= K_RD;
                end else begin
                  kind    <= K_WR;
                  shreg   <= tx_data;
                  tx_take <= 1'b1;
                end
              end
            end
          end
        end
        ST_STOP_LO: begin
          sda_oe <= 1'b1;
          if (tmr_exp) begin
            scl_oe  <= 1'b0;
            tmr_clr <= 1'b1;
            state   <= ST_STOP_HI;
          end
        end
        ST_STOP_HI: begin
          if (tmr_exp) begin
            sda_oe  <= 1'b0;
            tmr_clr <= 1'b1;
            state   <= ST_STOP_END;
          end
        end
        ST_STOP_END: begin
          if (tmr_exp) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  arb_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> (!scl_oe && !sda_oe && done));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1
  sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HI && $past(state) == ST_HI) |-> $stable(sda_oe));

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> ($past(scl_f) && $past(sda_f) && state == ST_IDLE));
endmodule

// File: tb/sim_i2c_arb_master.sv
module sim_i2c_arb_master;
  localparam int FILT = 4;
  localparam int HS   = 20;
  localparam int HF   = 8;
  localparam int STR  = 30;
  localparam logic [6:0] TADDR = 7'h5A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [6:0] cmd_addr = '0;
  logic       cmd_read = 1'b0;
  logic [7:0] cmd_len = '0;
  logic       cmd_fast = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_take;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       done;
  logic       nack;
  logic       arb_lost;
  logic       scl_oe;
  logic       sda_oe;
  logic       scl_ln;
  logic       sda_ln;
  logic       sda_m;

  always #10 clk = ~clk;

  int nvec = 0;
  int nbad = 0;

  // target model state
  int   str_cnt = 0, gl_cnt = 0, gl_wait = 0;
  int   s_bit = -1, nw = 0, s_ri = 0, nstart = 0, nstop = 0;
  bit   s_addr = 0, s_sel = 0, s_rd = 0, s_go = 0, s_pull = 0;
  bit   p_scl = 1, p_sda = 1;
  logic [7:0] s_sh = '0, s_agot = '0, cur;
  logic [7:0] wr_got [16];
  bit   mack [16];
  int   nack_at = 99;
  bit   stretch_en = 0, glitch_en = 0, rival_en = 0, rival_hold = 0;
  int   rival_bit = 0, glitch_bit = 0, gl_delay = 0;
  logic rival_pull;

  // host side
  logic [7:0] txbuf [16];
  logic [7:0] rxbuf [16];
  int tx_idx = 0, nrx = 0;
  int lrun = 0, lmin = 9999, lmax = 0, sclrise = 0;
  bit p_oe = 0;

  assign rival_pull = rival_en && s_addr && (s_bit == rival_bit);
  assign scl_ln = !scl_oe && (str_cnt == 0);
  assign sda_ln = !sda_oe && !s_pull && !rival_pull && !rival_hold;
  assign sda_m  = sda_ln && (gl_cnt == 0);

  i2c_arb_master #(.FILT_LEN(FILT), .HALF_STD(HS), .HALF_FAST(HF), .CNT_W(8)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_read(cmd_read), .cmd_len(cmd_len), .cmd_fast(cmd_fast),
    .tx_data(tx_data), .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid),
    .done(done), .nack(nack), .arb_lost(arb_lost),
    .scl_i(scl_ln), .sda_i(sda_m), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] rd_pat(int i);
    return 8'((i * 73) ^ 8'h9C);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // target model, sampled away from the active edge
  always @(negedge clk) begin
    if (str_cnt > 0) str_cnt--;
    if (gl_cnt > 0) gl_cnt--;
    if (gl_wait > 0) begin
      gl_wait--;
      if (gl_wait == 0) gl_cnt = 2;
    end
    if (scl_ln && p_scl && p_sda && !sda_ln) begin
      s_bit = -1; s_addr = 1; s_sel = 0; s_pull = 0; s_go = 1;
      nw = 0; s_ri = 0; nstart++;
    end else if (scl_ln && p_scl && !p_sda && sda_ln) begin
      nstop++; s_sel = 0; s_pull = 0; s_addr = 0;
    end else if (!p_scl && scl_ln) begin
      if (s_bit >= 0 && s_bit < 8) s_sh = {s_sh[6:0], sda_ln};
      else if (s_bit == 8 && s_sel && s_rd && !s_addr) begin
        mack[s_ri] = !sda_ln; s_go = !sda_ln; s_ri++;
      end
      if (glitch_en && s_addr && s_bit == glitch_bit) gl_wait = gl_delay;
    end else if (p_scl && !scl_ln) begin
      if (stretch_en) str_cnt = STR;
      s_bit++;
      if (s_bit == 9) begin s_bit = 0; s_addr = 0; end
      if (s_bit == 8) begin
        if (s_addr) begin
          s_agot = s_sh; s_sel = (s_sh[7:1] == TADDR); s_rd = s_sh[0]; s_pull = s_sel;
        end else if (s_sel && !s_rd) begin
          wr_got[nw] = s_sh; s_pull = (nw != nack_at); nw++;
        end else s_pull = 0;
      end else begin
        cur = rd_pat(s_ri);
        s_pull = s_sel && s_rd && !s_addr && s_go && !cur[7 - s_bit];
      end
    end
    p_scl = scl_ln; p_sda = sda_ln;
  end

  // host-side monitors
  always @(negedge clk) begin
    if (tx_take) begin tx_idx++; tx_data = txbuf[tx_idx]; end
    if (rx_valid) begin rxbuf[nrx] = rx_data; nrx++; end
    if (scl_oe && !p_oe) sclrise++;
    p_oe = scl_oe;
    if (scl_oe) lrun++;
    else if (lrun > 0) begin
      if (lrun < lmin) lmin = lrun;
      if (lrun > lmax) lmax = lrun;
      lrun = 0;
    end
  end

  task automatic issue(input logic [6:0] a, input bit rd, input int len, input bit fast);
    int t = 0;
    tx_idx = 0; nrx = 0; tx_data = txbuf[0]; lmin = 9999; lmax = 0;
    @(negedge clk);
    while (!cmd_ready && t < 20000) begin @(negedge clk); t++; end
    chk(cmd_ready, "R10 ready before command", cmd_ready, 1);
    cmd_addr = a; cmd_read = rd; cmd_len = 8'(len); cmd_fast = fast; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done, "R12 done reached", done, 1);
  endtask

  task automatic txn(input logic [6:0] a, input bit rd, input int len, input bit fast,
                     input int nk, input bit str, input string tag);
    bit e_nack; int e_n; bit got_nack; int st0;
    for (int i = 0; i < 16; i++) txbuf[i] = 8'($urandom);
    nack_at = nk; stretch_en = str; st0 = nstop;
    issue(a, rd, len, fast);
    got_nack = nack;
    if (a != TADDR) begin e_nack = 1; e_n = 0; end
    else if (!rd) begin e_nack = (nk < len); e_n = (nk < len) ? nk + 1 : len; end
    else begin e_nack = 0; e_n = len; end
    chk(got_nack == e_nack, {"R4 nack flag ", tag}, got_nack, e_nack);
    chk(!arb_lost, {"R8 no loss ", tag}, arb_lost, 0);
    chk(s_agot == {a, rd}, {"R1 address byte ", tag}, s_agot, {a, rd});
    if (!rd) begin
      chk(tx_idx == e_n, {"R2 take count ", tag}, tx_idx, e_n);
      chk(nw == e_n, {"R2 bytes at target ", tag}, nw, e_n);
      for (int i = 0; i < e_n && i < 16; i++)
        chk(wr_got[i] == txbuf[i], {"R2 write data ", tag}, wr_got[i], txbuf[i]);
    end else begin
      chk(nrx == e_n, {"R3 read count ", tag}, nrx, e_n);
      for (int i = 0; i < e_n && i < 16; i++) begin
        chk(rxbuf[i] == rd_pat(i), {"R3 read data ", tag}, rxbuf[i], rd_pat(i));
        chk(mack[i] == (i != e_n - 1), {"R3 master ack ", tag}, mack[i], (i != e_n - 1));
      end
    end
    chk(lmin == (fast ? HF : HS) + 1 && lmax == lmin, {"R6 low time ", tag}, lmax, (fast ? HF : HS) + 1);
    @(negedge clk);
    chk(!done, {"R12 done one cycle ", tag}, done, 0);
    chk(nack == got_nack, {"R12 nack held ", tag}, nack, got_nack);
    chk(nstop == st0 + 1, {"R4 stop seen ", tag}, nstop - st0, 1);
    stretch_en = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL R12 watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int sr;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11
    chk(!scl_oe && !sda_oe, "R11 wires released", {scl_oe, sda_oe}, 0);
    chk(!done && !tx_take && !rx_valid, "R11 pulses low", {done, tx_take, rx_valid}, 0);
    repeat (12) @(negedge clk);
    chk(cmd_ready, "R11 ready after reset", cmd_ready, 1);

    txn(TADDR, 0, 3, 0, 99, 0, "wr3 std");
    txn(TADDR, 1, 3, 1, 99, 0, "rd3 fast");
    txn(7'h11, 0, 2, 1, 99, 0, "addr nack");
    txn(7'h11, 1, 2, 0, 99, 0, "addr nack rd");
    txn(TADDR, 0, 4, 1, 1, 0, "wr nack byte1");
    txn(TADDR, 0, 0, 0, 99, 0, "R5 zero count");
    chk(nw == 0, "R5 no data byte", nw, 0);
    txn(TADDR, 1, 2, 0, 99, 1, "R7 stretched rd");
    txn(TADDR, 0, 2, 1, 99, 1, "R7 stretched wr");
    txn(TADDR, 1, 1, 1, 99, 0, "rd1");

    // R9: short pulse just before the sample of address bit A6 (=1)
    glitch_en = 1; glitch_bit = 0; gl_delay = HF + 2;
    txn(TADDR, 0, 1, 1, 99, 0, "R9 glitch");
    glitch_en = 0;

    // R8: another master holds SDA low for address bit A4 (=1)
    rival_en = 1; rival_bit = 2;
    for (int i = 0; i < 16; i++) txbuf[i] = 8'($urandom);
    issue(TADDR, 0, 2, 1);
    chk(arb_lost, "R8 arb_lost", arb_lost, 1);
    chk(!nack, "R8 no nack", nack, 0);
    chk(!scl_oe && !sda_oe, "R8 wires released", {scl_oe, sda_oe}, 0);
    sr = sclrise;
    repeat (200) @(negedge clk);
    chk(sclrise == sr, "R8 no further clock", sclrise - sr, 0);
    chk(arb_lost, "R12 arb_lost held", arb_lost, 1);
    rival_en = 0;

    // R10: SDA held low by another device while idle
    repeat (20) @(negedge clk);
    rival_hold = 1;
    repeat (20) @(negedge clk);
    cmd_valid = 1; cmd_addr = TADDR; cmd_read = 0; cmd_len = 0;
    repeat (40) @(negedge clk);
    chk(!cmd_ready, "R10 held bus not ready", cmd_ready, 0);
    chk(!scl_oe && !sda_oe, "R10 no command taken", {scl_oe, sda_oe}, 0);
    cmd_valid = 0;
    rival_hold = 0;
    repeat (20) @(negedge clk);
    chk(cmd_ready, "R10 ready after release", cmd_ready, 1);

    for (int k = 0; k < 24; k++) begin
      logic [6:0] a; bit rd; int len; bit fast; int nk; bit str;
      a    = ($urandom % 5 == 0) ? 7'h11 : TADDR;
      rd   = $urandom % 2;
      len  = rd ? 1 + ($urandom % 4) : ($urandom % 5);
      fast = $urandom % 2;
      nk   = $urandom % 6;
      str  = ($urandom % 4 == 0);
      txn(a, rd, len, fast, nk, str, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule